// File: doc/BRIEF.md
# Cartesian PI Loop with Table-Driven IF Synthesizer

This block closes an amplitude-and-phase feedback loop in rectangular coordinates. Each clock it subtracts a measured in-phase and quadrature pair from a target pair. It passes each difference through its own proportional-plus-integral stage and registers the result as the drive pair. Both stages share one pair of host-programmed gains in an unsigned fixed-point format with 16 fraction bits. That format holds both a proportional gain near 0.8 and an integral gain near 0.0008.

The drive pair is mixed onto a 16-entry sine/cosine table. The phase index advances 5 steps per clock, so the output repeats every 16 samples after 5 intermediate-frequency periods. The result is one real sample per clock for a DAC running at 16/5 of the intermediate frequency. When the loop is switched off, fixed host values drive the synthesizer directly. Each integrator is clamped to a programmable bound and restarts from zero whenever the loop is switched on.

Top module: `iq_pi_nco_drive`

## Requirements
- R1: Each channel error is target minus measured, taken at DW+1 bits. The proportional term is floor(kp·error / 2^16), where kp is unsigned with 16 fraction bits (65536 = 1.0).
- R2: While loop_en is high, drv_i/drv_q take the sum of the proportional term and the integrator term, saturated to signed DW bits. The update lands on the clock edge that samples the inputs.
- R3: On each enabled edge that is not a switch-on edge, the integrator adds ki·error. Its contribution to the drive is floor(integrator / 2^16), and an addition first shows in the drive one edge after it is made.
- R4: The integrator is clamped to ±(int_lim·2^16). With kp = 0 the drive therefore settles at ±int_lim.
- R5: On an edge where loop_en is high and was low at the previous edge, the integrator is cleared. The drive produced on that edge contains no integrator contribution.
- R6: While loop_en is low, drv_i/drv_q take ol_i/ol_q on the next edge, and the integrator holds its value.
- R7: nco_ph is 0 after reset and advances by 5 modulo 16 on every edge (112.5° per sample).
- R8: dac_out takes a registered value one edge after drv and nco_ph. With cos(k) and sin(k) set to round(2^14·cos/sin(k·22.5°)), that value is floor((drv_i·cos(nco_ph) − drv_q·sin(nco_ph) + 2^15) / 2^16), saturated to signed DACW bits.
- R9: While rst_n is low, drv_i, drv_q, dac_out and nco_ph are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | 1 = closed loop, 0 = fixed drive |
| set_i | input | DW | Target in-phase value, signed |
| set_q | input | DW | Target quadrature value, signed |
| meas_i | input | DW | Measured in-phase value, signed |
| meas_q | input | DW | Measured quadrature value, signed |
| kp | input | GW | Proportional gain, unsigned, 16 fraction bits |
| ki | input | GW | Integral gain, unsigned, 16 fraction bits |
| int_lim | input | DW-1 | Integrator bound in drive units |
| ol_i | input | DW | Fixed in-phase drive, signed |
| ol_q | input | DW | Fixed quadrature drive, signed |
| drv_i | output | DW | Registered in-phase drive |
| drv_q | output | DW | Registered quadrature drive |
| nco_ph | output | 4 | Synthesizer phase index |
| dac_out | output | DACW | Registered DAC sample, signed |

## Verification
The bench applies odd errors at a gain of 0.5 and a negative error at a gain of 0.8. A design that truncated toward zero instead of flooring would be off by one on the negative side. Errors near full scale and large gains would wrap the drive if the sum were not saturated. The integrator is driven into its bound and the loop is then switched off and on again. A design with a stale integrator, a one-cycle slip in the integral path, or no clear on switch-on would show the old bound, 25 or 50 in place of the exact expected values. Extreme fixed drives swept over all sixteen phases expose a wrong table sign per quadrant, a wrong phase step and missing output saturation.

// File: rtl/iq_pi_nco_drive.sv
module iq_pi_nco_drive #(
  parameter int DW   = 16,
  parameter int GW   = 20,
  parameter int GF   = 16,
  parameter int TW   = 16,
  parameter int DACW = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   loop_en,
  input  logic signed [DW-1:0]   set_i,
  input  logic signed [DW-1:0]   set_q,
  input  logic signed [DW-1:0]   meas_i,
  input  logic signed [DW-1:0]   meas_q,
  input  logic        [GW-1:0]   kp,
  input  logic        [GW-1:0]   ki,
  input  logic        [DW-2:0]   int_lim,
  input  logic signed [DW-1:0]   ol_i,
  input  logic signed [DW-1:0]   ol_q,
  output logic signed [DW-1:0]   drv_i,
  output logic signed [DW-1:0]   drv_q,
  output logic        [3:0]      nco_ph,
  output logic signed [DACW-1:0] dac_out
);
  localparam int EW = DW + 1;
  localparam int PW = GW + 1 + EW;
  localparam int SW = PW + 2;
  localparam int AW = DW + GF + 2;
  localparam int MW = DW + TW + 1;
  localparam int SH = (TW - 2) + (DW - DACW);
  localparam logic [3:0] PH_STEP = 4'd5;

  localparam logic signed [TW-1:0] M0 = TW'(2 ** (TW - 2));
  localparam logic signed [TW-1:0] M1 = TW'($rtoi(0.9238795325 * (2.0 ** (TW - 2)) + 0.5));
  localparam logic signed [TW-1:0] M2 = TW'($rtoi(0.7071067812 * (2.0 ** (TW - 2)) + 0.5));
  localparam logic signed [TW-1:0] M3 = TW'($rtoi(0.3826834324 * (2.0 ** (TW - 2)) + 0.5));

  localparam logic signed [SW-1:0] D_HI = SW'(2 ** (DW - 1) - 1);
  localparam logic signed [SW-1:0] D_LO = -D_HI - SW'(1);
  localparam logic signed [SW-1:0] A_HI = SW'(2 ** (DACW - 1) - 1);
  localparam logic signed [SW-1:0] A_LO = -A_HI - SW'(1);

  function automatic logic signed [SW-1:0] clip(input logic signed [SW-1:0] x,
                                                input logic signed [SW-1:0] hi,
                                                input logic signed [SW-1:0] lo);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic logic signed [TW-1:0] mag(input logic [3:0] k);
    case (k)
      4'd0:    return M0;
      4'd1:    return M1;
      4'd2:    return M2;
      4'd3:    return M3;
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [TW-1:0] cosv(input logic [3:0] k);
    if (k <= 4'd4)  return mag(k);
    if (k <= 4'd8)  return -mag(4'd8 - k);
    if (k <= 4'd12) return -mag(k - 4'd8);
    return mag(4'd0 - k);
  endfunction

  logic en_d;
  logic rise;
  assign rise = loop_en & ~en_d;

  logic signed [SW-1:0] lim_hi, lim_lo;
  assign lim_hi = SW'({int_lim, {GF{1'b0}}});
  assign lim_lo = -lim_hi;

  logic signed [DW-1:0] setv [2];
  logic signed [DW-1:0] measv[2];
  logic signed [DW-1:0] olv  [2];
  assign setv[0]  = set_i;
  assign setv[1]  = set_q;
  assign measv[0] = meas_i;
  assign measv[1] = meas_q;
  assign olv[0]   = ol_i;
  assign olv[1]   = ol_q;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [EW-1:0] err;
    logic signed [PW-1:0] pterm, iterm;
    logic signed [AW-1:0] acc, acc_eff;
    logic signed [SW-1:0] sum, pi_full;
    logic signed [DW-1:0] drv;

    assign err     = EW'(setv[c]) - EW'(measv[c]);
    assign pterm   = $signed({1'b0, kp}) * err;
    assign iterm   = $signed({1'b0, ki}) * err;
    assign acc_eff = rise ? '0 : acc;
    assign sum     = SW'(acc_eff) + SW'(iterm);
    assign pi_full = SW'(pterm >>> GF) + SW'(acc_eff >>> GF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc <= '0;
        drv <= '0;
      end else begin
        if (rise)         acc <= '0;
        else if (loop_en) acc <= AW'(clip(sum, lim_hi, lim_lo));
        drv <= loop_en ? DW'(clip(pi_full, D_HI, D_LO)) : olv[c];
      end
    end
  end

  assign drv_i = g_ch[0].drv;
  assign drv_q = g_ch[1].drv;

  logic signed [TW-1:0] cv, sv;
  logic signed [MW-1:0] mix, rnd;
  assign cv  = cosv(nco_ph);
  assign sv  = cosv(nco_ph - 4'd4);
  assign mix = MW'(drv_i * cv) - MW'(drv_q * sv);
  assign rnd = (mix + MW'(2 ** (SH - 1))) >>> SH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d    <= 1'b0;
      nco_ph  <= '0;
      dac_out <= '0;
    end else begin
      en_d    <= loop_en;
      nco_ph  <= nco_ph + PH_STEP;
      dac_out <= DACW'(clip(SW'(rnd), A_HI, A_LO));
    end
  end
endmodule

// File: rtl/iq_pi_nco_drive_chk.sv
module iq_pi_nco_drive_chk #(
  parameter int DW   = 16,
  parameter int GW   = 20,
  parameter int DACW = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   loop_en,
  input logic        [GW-1:0]   kp,
  input logic signed [DW-1:0]   ol_i,
  input logic signed [DW-1:0]   ol_q,
  input logic signed [DW-1:0]   drv_i,
  input logic signed [DW-1:0]   drv_q,
  input logic        [3:0]      nco_ph,
  input logic signed [DACW-1:0] dac_out
);
  a_r7_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> nco_ph == 4'($past(nco_ph) + 4'd5));

  a_r6_open_loop: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (drv_i == $past(ol_i)) && (drv_q == $past(ol_q)));

  a_r5_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(loop_en) && kp == '0) |=> (drv_i == '0) && (drv_q == '0));

  a_r8_zero_drive_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_i == '0 && drv_q == '0) |=> dac_out == '0);
endmodule

bind iq_pi_nco_drive iq_pi_nco_drive_chk #(.DW(DW), .GW(GW), .DACW(DACW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .kp(kp), .ol_i(ol_i), .ol_q(ol_q),
  .drv_i(drv_i), .drv_q(drv_q), .nco_ph(nco_ph), .dac_out(dac_out)
);

// File: tb/sim_iq_pi_nco_drive.sv
module sim_iq_pi_nco_drive;
  localparam int PERIOD = 10;
  localparam int NV = 6;
  // set_i, meas_i, set_q, meas_q, kp, exp_i, exp_q
  localparam int VEC [NV][7] = '{
    '{1000, 400, -200, 300, 65536, 600, -500},
    '{7, 0, 0, 7, 32768, 3, -4},
    '{1000, 0, 0, 1000, 52429, 800, -801},
    '{10000, -10000, -10000, 10000, 262144, 32767, -32768},
    '{32767, -32768, -32768, 32767, 65536, 32767, -32768},
    '{5000, -3000, 123, -77, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_en = 1'b0;
  logic signed [15:0] set_i = '0, set_q = '0, meas_i = '0, meas_q = '0, ol_i = '0, ol_q = '0;
  logic [19:0] kp = '0, ki = '0;
  logic [14:0] int_lim = '0;
  logic signed [15:0] drv_i, drv_q;
  logic [3:0] nco_ph;
  logic signed [13:0] dac_out;

  int total = 0;
  int bad = 0;

  always #(PERIOD / 2) clk = ~clk;

  iq_pi_nco_drive u0 (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .set_i(set_i), .set_q(set_q), .meas_i(meas_i), .meas_q(meas_q),
    .kp(kp), .ki(ki), .int_lim(int_lim), .ol_i(ol_i), .ol_q(ol_q),
    .drv_i(drv_i), .drv_q(drv_q), .nco_ph(nco_ph), .dac_out(dac_out)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint tab(input int k);
    real a;
    a = $cos(k * 22.5 * 3.14159265358979 / 180.0) * 16384.0;
    return longint'($rtoi($floor(a + 0.5)));
  endfunction

  function automatic longint dac_model(input longint di, input longint dq, input int ph);
    longint m;
    m = (di * tab(ph) - dq * tab((ph + 12) % 16) + 32768) >>> 16;
    if (m > 8191) m = 8191;
    if (m < -8192) m = -8192;
    return m;
  endfunction

  task automatic dac_sweep(input logic signed [15:0] vi, input logic signed [15:0] vq);
    longint pi, pq;
    int pp;
    @(negedge clk);
    loop_en = 1'b0; ol_i = vi; ol_q = vq;
    repeat (2) @(negedge clk);
    pi = drv_i; pq = drv_q; pp = nco_ph;
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      chk("R7 phase step", nco_ph, (pp + 5) % 16);
      chk("R8 dac sample", dac_out, dac_model(pi, pq, pp));
      pi = drv_i; pq = drv_q; pp = nco_ph;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset drv_i", drv_i, 0);
    chk("R9 reset drv_q", drv_q, 0);
    chk("R9 reset dac", dac_out, 0);
    chk("R9 reset phase", nco_ph, 0);
    rst_n = 1'b1;
    ki = '0; int_lim = 15'd1000; loop_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      set_i = 16'(VEC[v][0]); meas_i = 16'(VEC[v][1]);
      set_q = 16'(VEC[v][2]); meas_q = 16'(VEC[v][3]);
      kp = 20'(VEC[v][4]);
      @(negedge clk);
      chk("R1 R2 prop drv_i", drv_i, VEC[v][5]);
      chk("R1 R2 prop drv_q", drv_q, VEC[v][6]);
    end

    loop_en = 1'b0; kp = '0; ol_i = '0; ol_q = '0;
    @(negedge clk);
    ki = 20'd16384; set_i = 16'sd100; meas_i = '0; set_q = '0; meas_q = 16'sd100;
    int_lim = 15'd1000; loop_en = 1'b1;
    @(negedge clk);
    chk("R5 first enabled edge i", drv_i, 0);
    repeat (5) @(negedge clk);
    chk("R3 integrator i", drv_i, 100);
    chk("R3 integrator q", drv_q, -100);
    int_lim = 15'd60;
    repeat (3) @(negedge clk);
    chk("R4 clamp i", drv_i, 60);
    chk("R4 clamp q", drv_q, -60);

    loop_en = 1'b0; ol_i = 16'sd1234; ol_q = -16'sd4321;
    @(negedge clk);
    chk("R6 fixed drive i", drv_i, 1234);
    chk("R6 fixed drive q", drv_q, -4321);
    @(negedge clk);
    loop_en = 1'b1;
    @(negedge clk);
    chk("R5 clear on switch-on i", drv_i, 0);
    chk("R5 clear on switch-on q", drv_q, 0);
    repeat (2) @(negedge clk);
    chk("R5 restart from zero i", drv_i, 25);
    chk("R5 restart from zero q", drv_q, -25);

    dac_sweep(16'sd8000, 16'sd0);
    dac_sweep(16'sd0, 16'sd8000);
    dac_sweep(16'sd32767, -16'sd32768);
    dac_sweep(-16'sd1000, 16'sd3000);
    dac_sweep(-16'sd32768, -16'sd32768);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule